// File: doc/BRIEF.md
# Byte Search Compare Step Engine

This block carries out one step of a memory search for an 8-bit processor core. On a start pulse it takes a snapshot of the accumulator, the flag byte, the 16-bit pointer and the 16-bit counter. It then fetches the byte at the pointer through a request/acknowledge read port and subtracts that byte from the accumulator. The difference is used only for the flags; the accumulator itself is never written. The block moves the pointer one place up or down, lowers the counter by one, and assembles the complete flag byte, including the two otherwise unused bits 5 and 3.

The surrounding core sets a direction input and a repeat input. In repeat mode the engine also decides whether the search goes on. It goes on when the counter has not reached zero and no match was found. In that case it asks the core to move the program counter back by two and reports the longer cost in clock states. The core loops by feeding the updated pointer, counter and flags back in on the next start. Decoding instructions and handling interrupts are left to the core.

Top module: `mem_scan_cmp`

## Requirements
- R1: A start seen while idle takes a snapshot of the inputs and raises `rdReq` the next cycle with `rdAddr` equal to the captured pointer. Both hold until the first cycle in which `rdAck` is sampled high. A start seen while a step is in progress has no effect on that step or its results.
- R2: With d = (accumulator − fetched byte) mod 256, flag bit 7 equals bit 7 of d, and flag bit 6 is set exactly when d is zero.
- R3: Flag bit 1 is always set in the result. Flag bit 0 is copied unchanged from bit 0 of the flag byte given at start.
- R4: Flag bit 4 is set exactly when the low nibble of the accumulator is less than the low nibble of the fetched byte (borrow out of bit 3).
- R5: With e = d − (flag bit 4 ? 1 : 0) mod 256, flag bit 3 equals bit 3 of e and flag bit 5 equals bit 1 of e.
- R6: `cntOut` is the captured counter minus one mod 65536, so 0 wraps to 0xFFFF. Flag bit 2 is set exactly when `cntOut` is nonzero.
- R7: `ptrOut` is the captured pointer plus one when `dirDown` was 0 at start and minus one when it was 1, wrapping mod 65536. The read always uses the pointer as it was before the step.
- R8: `rewindPc` is set only when `repeatMode` was 1 at start, flag bit 2 is set and flag bit 6 is clear. In single mode it is always 0.
- R9: `stateCount` is 21 when `rewindPc` is set and 16 otherwise.
- R10: `done` is high for exactly one cycle: the cycle after `rdAck` is sampled with a request pending. All results appear in that cycle and hold until the next step completes.
- R11: After reset, `done`, `rdReq`, `rewindPc`, `ptrOut`, `cntOut`, `flagsOut` and `stateCount` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one search step (taken only when idle) |
| dirDown | input | 1 | 1: pointer steps down, 0: steps up |
| repeatMode | input | 1 | 1: decide whether the search continues |
| accIn | input | 8 | Accumulator value to compare against |
| flagsIn | input | 8 | Incoming flag byte (bit 0 is kept) |
| ptrIn | input | 16 | Pointer to the byte to fetch |
| cntIn | input | 16 | Remaining byte count |
| rdReq | output | 1 | Memory read request |
| rdAddr | output | 16 | Memory read address |
| rdAck | input | 1 | Read data valid this cycle |
| rdData | input | 8 | Byte returned by memory |
| ptrOut | output | 16 | Updated pointer |
| cntOut | output | 16 | Updated count |
| flagsOut | output | 8 | Result flag byte |
| rewindPc | output | 1 | Ask the core to move PC back by two |
| stateCount | output | 5 | Clock states charged for this step |
| done | output | 1 | One-cycle completion strobe |

## Verification
Several kinds of step are tried, each chosen to separate one piece of the result from the others. Equal and unequal bytes separate the zero flag from the sign bit. Nibble pairs with and without a low-nibble borrow show whether bits 5 and 3 come from the corrected difference or the raw one. Counts of 1, 0 and larger values tell a counter that reaches zero from one that wraps, and repeat runs with a mid-buffer match, with exhaustion and in single mode separate the three rewind outcomes. Read latencies from zero to several cycles, plus a second start while a read is pending, test the handshake and the one-cycle strobe. A repeat loop fed back through the ports, followed by a pseudo-random sweep, is checked against a cycle-level model on every clock.

// File: rtl/mem_scan_pkg.sv
package mem_scan_pkg;
  // Flag byte layout (the core consumes these bit positions directly)
  localparam int FLAG_C  = 0;
  localparam int FLAG_N  = 1;
  localparam int FLAG_PV = 2;
  localparam int FLAG_X3 = 3;
  localparam int FLAG_H  = 4;
  localparam int FLAG_X5 = 5;
  localparam int FLAG_Z  = 6;
  localparam int FLAG_S  = 7;
  localparam int FLAG_W  = 8;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // snapshot the start operands
    logic capture;  // fetched byte valid: register all results
  } scanStrobe_t;
endpackage

// File: rtl/mem_scan_flags.sv
module mem_scan_flags
  import mem_scan_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic [DATA_W-1:0] accVal,
  input  logic [DATA_W-1:0] memVal,
  input  logic              carryIn,
  input  logic [CNT_W-1:0]  cntNext,
  output logic [FLAG_W-1:0] flags,
  output logic              hit
);
  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] diffLess;
  logic [DATA_W-1:0] adjusted;
  logic              halfBorrow;

  // Both candidates for the undocumented bits are formed in parallel,
  // then the nibble borrow selects one (keeps the path one adder deep).
  assign diff       = accVal - memVal;
  assign diffLess   = accVal - memVal - DATA_W'(1);
  assign halfBorrow = accVal[3:0] < memVal[3:0];
  assign adjusted   = halfBorrow ? diffLess : diff;
  assign hit        = (diff == '0);

  always_comb begin
    flags          = '0;
    flags[FLAG_S]  = diff[DATA_W-1];
    flags[FLAG_Z]  = hit;
    flags[FLAG_X5] = adjusted[1];
    flags[FLAG_H]  = halfBorrow;
    flags[FLAG_X3] = adjusted[3];
    flags[FLAG_PV] = |cntNext;
    flags[FLAG_N]  = 1'b1;
    flags[FLAG_C]  = carryIn;
  end
endmodule

// File: rtl/mem_scan_ctrl.sv
module mem_scan_ctrl
  import mem_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        rdAck,
  output scanStrobe_t strb,
  output logic        rdReq,
  output logic        done
);
  typedef enum logic [0:0] {ST_IDLE, ST_READ} scanState_t;
  scanState_t state, stateNext;

  always_comb begin
    strb         = '0;
    strb.load    = (state == ST_IDLE) && start;
    strb.capture = (state == ST_READ) && rdAck;
    stateNext    = state;
    if (strb.load)    stateNext = ST_READ;
    if (strb.capture) stateNext = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.capture;
    end
  end

  assign rdReq = (state == ST_READ);

  // R1: a pending request stays up until acknowledged
  a_r1_req_holds: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq);
  // R10: acknowledge ends the request and yields done next cycle
  a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && rdAck |=> done && !rdReq);
  // R10: done is a single-cycle strobe
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/mem_scan_dp.sv
module mem_scan_dp
  import mem_scan_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int BASE_STATES   = 16,
  parameter int REPEAT_STATES = 5,
  parameter int STATE_W       = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanStrobe_t       strb,
  input  logic              dirDown,
  input  logic              repeatMode,
  input  logic [DATA_W-1:0] accIn,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [ADDR_W-1:0] ptrIn,
  input  logic [CNT_W-1:0]  cntIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] ptrOut,
  output logic [CNT_W-1:0]  cntOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              rewindPc,
  output logic [STATE_W-1:0] stateCount
);
  localparam logic [STATE_W-1:0] COST_STOP = STATE_W'(BASE_STATES);
  localparam logic [STATE_W-1:0] COST_GO   = STATE_W'(BASE_STATES + REPEAT_STATES);

  logic [DATA_W-1:0] accQ;
  logic              carryQ;
  logic [ADDR_W-1:0] ptrQ;
  logic [CNT_W-1:0]  cntQ;
  logic              dirQ;
  logic              repQ;

  logic [CNT_W-1:0]  cntNext;
  logic [ADDR_W-1:0] ptrNext;
  logic [FLAG_W-1:0] flagsNext;
  logic              hit;
  logic              goOn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ   <= '0;
      carryQ <= 1'b0;
      ptrQ   <= '0;
      cntQ   <= '0;
      dirQ   <= 1'b0;
      repQ   <= 1'b0;
    end else if (strb.load) begin
      accQ   <= accIn;
      carryQ <= flagsIn[FLAG_C];
      ptrQ   <= ptrIn;
      cntQ   <= cntIn;
      dirQ   <= dirDown;
      repQ   <= repeatMode;
    end
  end

  assign rdAddr  = ptrQ;
  assign cntNext = cntQ - CNT_W'(1);
  assign ptrNext = dirQ ? (ptrQ - ADDR_W'(1)) : (ptrQ + ADDR_W'(1));

  mem_scan_flags #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_flags (
    .accVal  (accQ),
    .memVal  (rdData),
    .carryIn (carryQ),
    .cntNext (cntNext),
    .flags   (flagsNext),
    .hit     (hit)
  );

  assign goOn = repQ && flagsNext[FLAG_PV] && !hit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrOut     <= '0;
      cntOut     <= '0;
      flagsOut   <= '0;
      rewindPc   <= 1'b0;
      stateCount <= '0;
    end else if (strb.capture) begin
      ptrOut     <= ptrNext;
      cntOut     <= cntNext;
      flagsOut   <= flagsNext;
      rewindPc   <= goOn;
      stateCount <= goOn ? COST_GO : COST_STOP;
    end
  end

  // R3: subtract flag set, carry carried from the snapshot
  a_r3_sub_and_carry: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> flagsOut[FLAG_N] && (flagsOut[FLAG_C] == $past(carryQ)));
  // R6: counter steps down by one per step
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> cntOut == CNT_W'($past(cntQ) - CNT_W'(1)));
  // R8: a rewind needs a live count and no match
  a_r8_rewind_gate: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !rewindPc || (flagsOut[FLAG_PV] && !flagsOut[FLAG_Z]));
  // R8: single mode never rewinds
  a_r8_single_no_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture && !repQ |=> !rewindPc);
  // R9: the cost agrees with the rewind decision
  a_r9_cost_match: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (stateCount == COST_GO) == rewindPc);
  // R1: operands are frozen while the read is pending
  a_r1_addr_frozen: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load && !strb.capture |=> $stable(rdAddr));
endmodule

// File: rtl/mem_scan_cmp.sv
module mem_scan_cmp
  import mem_scan_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int CNT_W         = 16,
  parameter int BASE_STATES   = 16,
  parameter int REPEAT_STATES = 5,
  localparam int STATE_W      = $clog2(BASE_STATES + REPEAT_STATES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               dirDown,
  input  logic               repeatMode,
  input  logic [DATA_W-1:0]  accIn,
  input  logic [7:0]         flagsIn,
  input  logic [ADDR_W-1:0]  ptrIn,
  input  logic [CNT_W-1:0]   cntIn,
  output logic               rdReq,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic               rdAck,
  input  logic [DATA_W-1:0]  rdData,
  output logic [ADDR_W-1:0]  ptrOut,
  output logic [CNT_W-1:0]   cntOut,
  output logic [7:0]         flagsOut,
  output logic               rewindPc,
  output logic [STATE_W-1:0] stateCount,
  output logic               done
);
  scanStrobe_t strb;

  mem_scan_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .rdAck (rdAck),
    .strb  (strb),
    .rdReq (rdReq),
    .done  (done)
  );

  mem_scan_dp #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CNT_W         (CNT_W),
    .BASE_STATES   (BASE_STATES),
    .REPEAT_STATES (REPEAT_STATES),
    .STATE_W       (STATE_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dirDown    (dirDown),
    .repeatMode (repeatMode),
    .accIn      (accIn),
    .flagsIn    (flagsIn),
    .ptrIn      (ptrIn),
    .cntIn      (cntIn),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .ptrOut     (ptrOut),
    .cntOut     (cntOut),
    .flagsOut   (flagsOut),
    .rewindPc   (rewindPc),
    .stateCount (stateCount)
  );

  // R10: results only change on the cycle done rises
  a_r10_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(ptrOut) && $stable(cntOut) && $stable(flagsOut));
endmodule

// File: tb/mem_scan_cmp_bench.sv
`timescale 1ns/1ps
module mem_scan_cmp_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        dirDown = 1'b0;
  logic        repeatMode = 1'b0;
  logic [7:0]  accIn = '0;
  logic [7:0]  flagsIn = '0;
  logic [15:0] ptrIn = '0;
  logic [15:0] cntIn = '0;
  logic        rdReq;
  logic [15:0] rdAddr;
  logic        rdAck = 1'b0;
  logic [7:0]  rdData = '0;
  logic [15:0] ptrOut;
  logic [15:0] cntOut;
  logic [7:0]  flagsOut;
  logic        rewindPc;
  logic [4:0]  stateCount;
  logic        done;

  always #2 clk = ~clk;

  mem_scan_cmp u_mem_scan_cmp (
    .clk(clk), .rstN(rstN), .start(start), .dirDown(dirDown),
    .repeatMode(repeatMode), .accIn(accIn), .flagsIn(flagsIn),
    .ptrIn(ptrIn), .cntIn(cntIn), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .ptrOut(ptrOut), .cntOut(cntOut),
    .flagsOut(flagsOut), .rewindPc(rewindPc), .stateCount(stateCount),
    .done(done)
  );

  int checks = 0;
  int fails = 0;
  bit running = 1'b0;
  int ackDelay = 0;
  int waitCnt = 0;
  logic [7:0] mem [0:255];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          mBusy, mDone, mRew, mCarry, mDir, mRep;
  int          mAcc, mPtr, mCnt, mPtrOut, mCntOut, mFlags, mStates;

  always @(posedge clk) begin : model
    int d, hb, e, nc, z, pv;
    if (!rstN) begin
      mBusy <= 0; mDone <= 0; mRew <= 0;
      mPtrOut <= 0; mCntOut <= 0; mFlags <= 0; mStates <= 0;
    end else begin
      mDone <= 0;
      if (!mBusy && start) begin
        mAcc <= int'(accIn); mCarry <= flagsIn[0]; mPtr <= int'(ptrIn);
        mCnt <= int'(cntIn); mDir <= dirDown; mRep <= repeatMode;
        mBusy <= 1;
      end else if (mBusy && rdAck) begin
        d  = (mAcc - int'(rdData)) & 255;
        hb = ((mAcc % 16) < (int'(rdData) % 16)) ? 1 : 0;
        e  = (d - hb) & 255;
        nc = (mCnt + 65535) % 65536;
        z  = (d == 0) ? 1 : 0;
        pv = (nc != 0) ? 1 : 0;
        mFlags  <= (d & 128) + 64 * z + ((e & 2) != 0 ? 32 : 0) + 16 * hb
                 + (e & 8) + 4 * pv + 2 + int'(mCarry);
        mCntOut <= nc;
        mPtrOut <= mDir ? (mPtr + 65535) % 65536 : (mPtr + 1) % 65536;
        mRew    <= mRep && pv == 1 && z == 0;
        mStates <= (mRep && pv == 1 && z == 0) ? 21 : 16;
        mBusy <= 0;
        mDone <= 1;
      end
    end
  end

  // ---------------- memory responder ----------------
  always @(negedge clk) begin
    if (!rstN) begin
      rdAck = 0; waitCnt = 0;
    end else if (rdAck) begin
      rdAck = 0; waitCnt = 0;
    end else if (rdReq) begin
      if (waitCnt >= ackDelay) begin
        rdAck = 1; rdData = mem[rdAddr[7:0]];
      end else waitCnt++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (running && rstN) begin
      chk("R10 done strobe", 32'(done), 32'(mDone));
      chk("R1 read request", 32'(rdReq), 32'(mBusy));
      if (mBusy) chk("R1 read address", 32'(rdAddr), 32'(mPtr));
      chk("R2 sign/zero", 32'(flagsOut & 8'hC0), 32'(mFlags & 'hC0));
      chk("R3 sub/carry", 32'(flagsOut & 8'h03), 32'(mFlags & 'h03));
      chk("R4 half borrow", 32'(flagsOut & 8'h10), 32'(mFlags & 'h10));
      chk("R5 bits 5 and 3", 32'(flagsOut & 8'h28), 32'(mFlags & 'h28));
      chk("R6 parity/overflow", 32'(flagsOut & 8'h04), 32'(mFlags & 'h04));
      chk("R6 count", 32'(cntOut), 32'(mCntOut));
      chk("R7 pointer", 32'(ptrOut), 32'(mPtrOut));
      chk("R8 rewind", 32'(rewindPc), 32'(mRew));
      chk("R9 state count", 32'(stateCount), 32'(mStates));
    end
  end

  task automatic runOp(input logic [7:0] a, input logic [7:0] f,
                       input logic [15:0] hl, input logic [15:0] bc,
                       input bit dn, input bit rp, input int dly, input bit poke);
    @(negedge clk);
    ackDelay = dly;
    accIn = a; flagsIn = f; ptrIn = hl; cntIn = bc;
    dirDown = dn; repeatMode = rp; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      accIn = ~a; ptrIn = hl ^ 16'h5555; cntIn = bc + 16'd7;
      dirDown = ~dn; repeatMode = ~rp; flagsIn = ~f; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stimulus
    logic [15:0] lfsr;
    logic [15:0] p, c;
    logic [7:0]  fl;
    int          iters;
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) % 256);
    repeat (4) @(negedge clk);
    // R11: reset state observed while reset is held and just after release
    chk("R11 done in reset", 32'(done), 0);
    chk("R11 rdReq in reset", 32'(rdReq), 0);
    rstN = 1;
    @(negedge clk);
    chk("R11 outputs after reset", {ptrOut, cntOut}, 0);
    chk("R11 flags/rewind/count after reset", {flagsOut, rewindPc, 3'b0, stateCount}, 0);
    running = 1;

    // R2: exact match, single mode
    mem[8'h20] = 8'h41;
    runOp(8'h41, 8'h00, 16'h1020, 16'd5, 0, 0, 0, 0);
    chk("R2 match sets zero", 32'(flagsOut[6]), 1);
    // R4/R5: borrow from low nibble, corrected difference 0x0E
    mem[8'h21] = 8'h01;
    runOp(8'h10, 8'h01, 16'h1021, 16'd9, 0, 0, 1, 0);
    chk("R5 corner flags", 32'(flagsOut), 32'h3F);
    // R2: sign from difference 0x80
    mem[8'h22] = 8'h80;
    runOp(8'h00, 8'hFE, 16'h0022, 16'd2, 0, 1, 2, 0);
    chk("R2 sign set", 32'(flagsOut[7]), 1);
    // R6: count 1 -> 0 ends a repeat search
    runOp(8'h00, 8'h00, 16'h0023, 16'd1, 0, 1, 0, 0);
    chk("R8 exhausted no rewind", 32'(rewindPc), 0);
    // R6: count 0 wraps to 0xFFFF
    runOp(8'h00, 8'h00, 16'h0024, 16'd0, 1, 1, 0, 0);
    chk("R6 wrap count", 32'(cntOut), 32'hFFFF);
    // R7: downward wrap of pointer
    mem[8'h00] = 8'h33;
    runOp(8'h12, 8'h01, 16'h0000, 16'd4, 1, 0, 3, 0);
    chk("R7 pointer wrap down", 32'(ptrOut), 32'hFFFF);
    runOp(8'h12, 8'h00, 16'hFFFF, 16'd4, 0, 0, 0, 0);
    chk("R7 pointer wrap up", 32'(ptrOut), 32'h0000);
    // R1: second start while the read is pending is ignored
    mem[8'h30] = 8'h05;
    runOp(8'h07, 8'h00, 16'h0130, 16'd3, 0, 1, 4, 1);
    chk("R1 ignored restart pointer", 32'(ptrOut), 32'h0131);
    chk("R9 continuing cost", 32'(stateCount), 21);

    // R8: repeat loop fed back through the ports, match at the fourth byte
    for (int i = 0; i < 6; i++) mem[8'h40 + i] = (i == 3) ? 8'h7E : 8'h11;
    p = 16'h0240; c = 16'd6; fl = 8'h01; iters = 0;
    do begin
      runOp(8'h7E, fl, p, c, 0, 1, iters % 3, 0);
      p = ptrOut; c = cntOut; fl = flagsOut; iters++;
    end while (rewindPc && iters < 20);
    chk("R8 loop iterations", 32'(iters), 4);
    chk("R7 loop final pointer", 32'(ptrOut), 32'h0244);
    chk("R3 loop carry kept", 32'(flagsOut[0]), 1);

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      runOp(lfsr[7:0], lfsr[15:8], {lfsr[3:0], lfsr[15:4]},
            (i % 5 == 0) ? 16'(i % 2) : {8'h00, lfsr[11:4]},
            lfsr[2], lfsr[5], i % 4, (i % 7 == 0));
    end

    running = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule